// File: doc/BRIEF.md
# Four-Bank SDRAM Command Front End

This block is the command-facing front end of a four-bank double-data-rate SDRAM device. On every rising clock edge it takes the chip select, the three active-low command strobes (row, column, write), the bank address and the address bus. It turns them into a decoded command, and from that command it keeps the open or closed state of each bank and the row each open bank holds. A registered report goes out one edge after the command: the command, the bank, the row address (on activate), the column address (on read or write), and the state of the overloaded A10 bit. On a read or write, A10 requests auto-precharge. On a precharge, A10 requests precharge of every bank.

Commands that break the bank protocol are flagged and leave the bank state as it was: an activate to a bank that is already open, or a read or write to a bank that is closed. An auto-precharge request closes its bank a fixed number of enabled cycles after the command, which stands in for the burst length. Clock enable low puts the block in a low-power hold. The per-byte write mask takes effect in the same cycle, with no register in its path.

The storage array, data-strobe timing, refresh timing and mode-register contents are outside this block. A mode-register load and a refresh are decoded and reported, and nothing more is done with them.

Top module: `sdram_cmd_front`

## Requirements
- R1: On a rising edge with clock enable high and chip select low, the strobe code {ras_n,cas_n,we_n} is decoded as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, 111 and 110 no-operation. The decoded command appears on cmd_o after that edge, coded as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode load. bank_o shows ba_i for any command other than no-op, and shows 0 for a no-op.
- R2: While chip select is high, the sampled command is reported as no-op, causes no bank change and raises no illegal flag. An auto-precharge countdown that is already running keeps counting.
- R3: A rising edge with clock enable low is reported as a no-op with lowpwr_o high after that edge. Bank state, stored rows and any auto-precharge countdown are frozen for that edge.
- R4: A legal activate reports row_o = addr_i[11:0], opens the bank selected by ba_i, and stores the row in open_row_o[12*b +: 12]. For every other command, row_o is 0.
- R5: A read or write reports col_o = addr_i[8:0] and autopre_o = addr_i[10]. For every other command, both are 0.
- R6: A precharge with addr_i[10] high reports preall_o = 1 and closes all four banks, whatever ba_i holds. With addr_i[10] low it closes only bank ba_i, and a precharge to a closed bank is legal.
- R7: A legal read or write with addr_i[10] high closes its bank at the AP_DELAY-th clock-enabled edge after the command edge. A further such command to the same bank before that edge restarts the count. An explicit precharge cancels the count.
- R8: An activate to an open bank, or a read or write to a closed bank, raises illegal_o after that edge and leaves bank_open_o and open_row_o unchanged.
- R9: byte_we_o is high in the same cycle exactly when wvld_i is high and dm_i is low. A high mask blocks the byte.
- R10: While reset is asserted, all banks are closed, all stored rows are zero and every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, high for normal decoding |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| addr_i | input | 12 | Address bus; bit 10 doubles as auto/all-precharge |
| wvld_i | input | 1 | A write data byte is present |
| dm_i | input | 1 | Write mask, high blocks the byte |
| cmd_o | output | 3 | Decoded command code (see R1) |
| bank_o | output | 2 | Bank of the reported command |
| row_o | output | 12 | Row address of a reported activate |
| col_o | output | 9 | Column address of a reported read or write |
| autopre_o | output | 1 | Read or write carried an auto-precharge request |
| preall_o | output | 1 | Precharge addressed all banks |
| illegal_o | output | 1 | Reported command broke the bank protocol |
| lowpwr_o | output | 1 | Last edge was taken with clock enable low |
| bank_open_o | output | 4 | Open flag per bank |
| open_row_o | output | 48 | Stored row per bank, bank b at bits 12*b+11..12*b |
| byte_we_o | output | 1 | Byte write permitted this cycle |

## Verification
The decoder is swept across all eight strobe codes under each of the four combinations of chip select and clock enable. This separates a decode error from faulty gating by select or by clock enable. Activates, reads and writes are then driven to every bank with distinct rows and columns and with both values of A10, so a swapped bank index, a truncated address field or a misread A10 shows up as a mismatch. Auto-precharge is followed edge by edge through deselected and clock-disabled cycles, including a restart of the count, which tells a count that runs from the command apart from one that is frozen or reloaded. The illegal-command, precharge-all, single-bank precharge and mask cases each check one corner of the protocol against a bench model.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MODE = 3'd6
  } cmd_e;

  // strobes are active low; code is {ras_n, cas_n, we_n}
  function automatic cmd_e decode_strobes(input logic [2:0] code);
    cmd_e c;
    case (code)
      3'b011:  c = CMD_ACT;
      3'b101:  c = CMD_RD;
      3'b100:  c = CMD_WR;
      3'b010:  c = CMD_PRE;
      3'b001:  c = CMD_REF;
      3'b000:  c = CMD_MODE;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sdram_rst_sync.sv
module sdram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W    = 12,
  parameter int AP_DELAY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             act_hit_i,
  input  logic             rw_hit_i,
  input  logic             rw_ap_i,
  input  logic             pre_hit_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o
);

  localparam int CNT_W = (AP_DELAY < 2) ? 1 : $clog2(AP_DELAY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(AP_DELAY - 1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire;

  assign expire = pend_q && (cnt_q == '0);

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (act_hit_i) begin
      open_d = 1'b1;
      row_d  = row_i;
    end else if (pre_hit_i) begin
      open_d = 1'b0;
      pend_d = 1'b0;
      cnt_d  = '0;
    end else if (rw_hit_i && rw_ap_i) begin
      pend_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (expire) begin
      open_d = 1'b0;
      pend_d = 1'b0;
    end else if (pend_q) begin
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en_i) begin
      open_q <= open_d;
      row_q  <= row_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;

endmodule

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_fe_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cke_i,
  input  logic                    cs_n_i,
  input  logic                    ras_n_i,
  input  logic                    cas_n_i,
  input  logic                    we_n_i,
  input  logic [$clog2(BANKS)-1:0] ba_i,
  input  logic [ROW_W-1:0]        addr_i,
  input  logic [BANKS-1:0]        bank_open_i,
  output logic [BANKS-1:0]        act_hit_o,
  output logic [BANKS-1:0]        rw_hit_o,
  output logic [BANKS-1:0]        pre_hit_o,
  output logic                    ap_flag_o,
  output logic [CMD_W-1:0]        cmd_o,
  output logic [$clog2(BANKS)-1:0] bank_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [COL_W-1:0]        col_o,
  output logic                    autopre_o,
  output logic                    preall_o,
  output logic                    illegal_o,
  output logic                    lowpwr_o
);

  localparam int BA_W = $clog2(BANKS);

  cmd_e             cmd_now;
  logic [BANKS-1:0] sel;
  logic             is_rw, sel_open, ap_bit;

  logic [CMD_W-1:0] cmd_d;
  logic [BA_W-1:0]  bank_d;
  logic [ROW_W-1:0] row_d;
  logic [COL_W-1:0] col_d;
  logic             autopre_d, preall_d, illegal_d, lowpwr_d;

  assign cmd_now = (cke_i && !cs_n_i) ? decode_strobes({ras_n_i, cas_n_i, we_n_i})
                                      : CMD_NOP;
  assign is_rw   = (cmd_now == CMD_RD) || (cmd_now == CMD_WR);
  assign ap_bit  = addr_i[AP_BIT];

  for (genvar g = 0; g < BANKS; g++) begin : g_sel
    assign sel[g]       = (ba_i == BA_W'(g));
    assign act_hit_o[g] = (cmd_now == CMD_ACT) && sel[g] && !bank_open_i[g];
    assign rw_hit_o[g]  = is_rw && sel[g] && bank_open_i[g];
    assign pre_hit_o[g] = (cmd_now == CMD_PRE) && (sel[g] || ap_bit);
  end

  assign sel_open  = |(sel & bank_open_i);
  assign ap_flag_o = ap_bit;

  always_comb begin
    cmd_d     = cmd_now;
    bank_d    = (cmd_now != CMD_NOP) ? ba_i : '0;
    row_d     = (cmd_now == CMD_ACT) ? addr_i : '0;
    col_d     = is_rw ? addr_i[COL_W-1:0] : '0;
    autopre_d = is_rw && ap_bit;
    preall_d  = (cmd_now == CMD_PRE) && ap_bit;
    illegal_d = ((cmd_now == CMD_ACT) && sel_open) || (is_rw && !sel_open);
    lowpwr_d  = !cke_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o     <= '0;
      bank_o    <= '0;
      row_o     <= '0;
      col_o     <= '0;
      autopre_o <= 1'b0;
      preall_o  <= 1'b0;
      illegal_o <= 1'b0;
      lowpwr_o  <= 1'b0;
    end else begin
      cmd_o     <= cmd_d;
      bank_o    <= bank_d;
      row_o     <= row_d;
      col_o     <= col_d;
      autopre_o <= autopre_d;
      preall_o  <= preall_d;
      illegal_o <= illegal_d;
      lowpwr_o  <= lowpwr_d;
    end
  end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdram_fe_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 9,
  parameter int AP_BIT   = 10,
  parameter int AP_DELAY = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cke_i,
  input  logic                      cs_n_i,
  input  logic                      ras_n_i,
  input  logic                      cas_n_i,
  input  logic                      we_n_i,
  input  logic [$clog2(BANKS)-1:0]  ba_i,
  input  logic [ROW_W-1:0]          addr_i,
  input  logic                      wvld_i,
  input  logic                      dm_i,
  output logic [2:0]                cmd_o,
  output logic [$clog2(BANKS)-1:0]  bank_o,
  output logic [ROW_W-1:0]          row_o,
  output logic [COL_W-1:0]          col_o,
  output logic                      autopre_o,
  output logic                      preall_o,
  output logic                      illegal_o,
  output logic                      lowpwr_o,
  output logic [BANKS-1:0]          bank_open_o,
  output logic [BANKS*ROW_W-1:0]    open_row_o,
  output logic                      byte_we_o
);

  logic             rst_sync_n;
  logic [BANKS-1:0] act_hit, rw_hit, pre_hit;
  logic             ap_flag;

  sdram_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdram_cmd_dec #(
    .BANKS  (BANKS),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) dec_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cke_i       (cke_i),
    .cs_n_i      (cs_n_i),
    .ras_n_i     (ras_n_i),
    .cas_n_i     (cas_n_i),
    .we_n_i      (we_n_i),
    .ba_i        (ba_i),
    .addr_i      (addr_i),
    .bank_open_i (bank_open_o),
    .act_hit_o   (act_hit),
    .rw_hit_o    (rw_hit),
    .pre_hit_o   (pre_hit),
    .ap_flag_o   (ap_flag),
    .cmd_o       (cmd_o),
    .bank_o      (bank_o),
    .row_o       (row_o),
    .col_o       (col_o),
    .autopre_o   (autopre_o),
    .preall_o    (preall_o),
    .illegal_o   (illegal_o),
    .lowpwr_o    (lowpwr_o)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sdram_bank_slot #(
      .ROW_W    (ROW_W),
      .AP_DELAY (AP_DELAY)
    ) slot_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .en_i      (cke_i),
      .act_hit_i (act_hit[b]),
      .rw_hit_i  (rw_hit[b]),
      .rw_ap_i   (ap_flag),
      .pre_hit_i (pre_hit[b]),
      .row_i     (addr_i),
      .open_o    (bank_open_o[b]),
      .row_o     (open_row_o[b*ROW_W +: ROW_W])
    );
  end

  // zero-latency write mask
  assign byte_we_o = wvld_i && !dm_i;

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk
  import sdram_fe_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cke_i,
  input logic                   cs_n_i,
  input logic                   dm_i,
  input logic [2:0]             cmd_o,
  input logic                   preall_o,
  input logic                   illegal_o,
  input logic                   lowpwr_o,
  input logic [BANKS-1:0]       bank_open_o,
  input logic [BANKS*ROW_W-1:0] open_row_o,
  input logic                   byte_we_o
);

  // R2
  a_r2_deselect_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_i && cs_n_i) |=> (cmd_o == CMD_NOP && !illegal_o));

  // R3
  a_r3_cke_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_i |=> (cmd_o == CMD_NOP && lowpwr_o && $stable(bank_open_o) && $stable(open_row_o)));

  // R4
  a_r4_open_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bank_open_o & ~$past(bank_open_o))) |-> (cmd_o == CMD_ACT));

  // R6
  a_r6_preall_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE && preall_o) |-> (bank_open_o == '0));

  // R8
  a_r8_illegal_keeps_rows: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(open_row_o));

  // R9
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dm_i |-> !byte_we_o);

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
  .BANKS (BANKS),
  .ROW_W (ROW_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .cke_i       (cke_i),
  .cs_n_i      (cs_n_i),
  .dm_i        (dm_i),
  .cmd_o       (cmd_o),
  .preall_o    (preall_o),
  .illegal_o   (illegal_o),
  .lowpwr_o    (lowpwr_o),
  .bank_open_o (bank_open_o),
  .open_row_o  (open_row_o),
  .byte_we_o   (byte_we_o)
);

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AP_DELAY   = 4;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n, cke, cs_n, ras_n, cas_n, we_n, wvld, dm;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic [2:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] row_o;
  logic [8:0]  col_o;
  logic        autopre_o, preall_o, illegal_o, lowpwr_o, byte_we_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_row_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // bench model
  int          cyc;
  bit          m_open [4];
  logic [11:0] m_row  [4];
  int          m_due  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_front #(.AP_DELAY(AP_DELAY)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n),
    .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .ba_i(ba), .addr_i(addr), .wvld_i(wvld), .dm_i(dm),
    .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .autopre_o(autopre_o), .preall_o(preall_o), .illegal_o(illegal_o),
    .lowpwr_o(lowpwr_o), .bank_open_o(bank_open_o),
    .open_row_o(open_row_o), .byte_we_o(byte_we_o)
  );

  task automatic model_clear();
    cyc = 0;
    for (int b = 0; b < 4; b++) begin
      m_open[b] = 1'b0; m_row[b] = '0; m_due[b] = -1;
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [2:0] s);
    case (s)
      3'b011: return 3'd1;
      3'b101: return 3'd2;
      3'b100: return 3'd3;
      3'b010: return 3'd4;
      3'b001: return 3'd5;
      3'b000: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check_vec(input string tag, input logic [91:0] got, input logic [91:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one command edge: model, drive, sample after edge
  task automatic step(input string tag, input bit k, input bit cs,
                      input logic [2:0] s, input logic [1:0] b_a, input logic [11:0] a);
    logic [2:0]  ec;
    logic [11:0] erow;
    logic [8:0]  ecol;
    logic        eap, epa, eill, rw;
    logic [3:0]  eopen;
    logic [47:0] erows;
    ec   = (k && !cs) ? exp_code(s) : 3'd0;
    rw   = (ec == 3'd2) || (ec == 3'd3);
    eill = ((ec == 3'd1) && m_open[b_a]) || (rw && !m_open[b_a]);
    erow = (ec == 3'd1) ? a : '0;
    ecol = rw ? a[8:0] : '0;
    eap  = rw && a[10];
    epa  = (ec == 3'd4) && a[10];
    if (k) begin
      cyc++;
      for (int b = 0; b < 4; b++) begin
        bit hit, exp_now;
        hit = (b_a == 2'(b));
        exp_now = (m_due[b] == cyc);
        if (ec == 3'd1 && hit && !m_open[b]) begin
          m_open[b] = 1'b1; m_row[b] = a;
        end else if (ec == 3'd4 && (hit || a[10])) begin
          m_open[b] = 1'b0; m_due[b] = -1;
        end else if (rw && hit && m_open[b] && a[10]) begin
          m_due[b] = cyc + AP_DELAY;
        end else if (exp_now) begin
          m_open[b] = 1'b0; m_due[b] = -1;
        end
      end
    end
    for (int b = 0; b < 4; b++) begin
      eopen[b] = m_open[b];
      erows[b*12 +: 12] = m_row[b];
    end
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = s; ba = b_a; addr = a;
    @(posedge clk);
    #1;
    check_vec(tag,
      {cmd_o, bank_o, row_o, col_o, autopre_o, preall_o, illegal_o, lowpwr_o, bank_open_o, open_row_o},
      {ec, (ec != 3'd0) ? b_a : 2'b00, erow, ecol, eap, epa, eill, !k, eopen, erows});
  endtask

  task automatic nop(input string tag);
    step(tag, 1'b1, 1'b0, 3'b111, 2'd0, 12'h000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    // R10: reset state visible at once
    check_vec("R10 reset state",
      {cmd_o, bank_o, row_o, col_o, autopre_o, preall_o, illegal_o, lowpwr_o, bank_open_o, open_row_o},
      '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) nop("R10 after release");
  endtask

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < WD_LIMIT) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = '0; addr = '0; wvld = 1'b0; dm = 1'b0;
    model_clear();
    do_reset();

    // R1, R2, R3: every strobe code under each select / enable pairing
    for (int k = 1; k >= 0; k--)
      for (int cs = 0; cs < 2; cs++)
        for (int s = 0; s < 8; s++)
          step((k == 0) ? "R3 cke low sweep" : (cs == 1) ? "R2 deselect sweep" : "R1 decode sweep",
               k[0], cs[0], 3'(s), 2'(s), 12'h2B5 ^ 12'(s * 12'h113));
    step("R6 clear", 1'b1, 1'b0, 3'b010, 2'd0, 12'h400);

    // R4: activate every bank with its own row
    for (int b = 0; b < 4; b++)
      step("R4 activate", 1'b1, 1'b0, 3'b011, 2'(b), 12'h3C5 + 12'(b * 12'h2A1));
    // R5: read/write each bank, both A10 values, distinct columns
    for (int b = 0; b < 4; b++) begin
      step("R5 read no-ap", 1'b1, 1'b0, 3'b101, 2'(b), 12'h0FF - 12'(b * 12'h021));
      step("R5 write", 1'b1, 1'b0, 3'b100, 2'(b), {1'b0, b[0], 1'b0, 9'h1A0 + 9'(b)});
    end
    for (int i = 0; i < AP_DELAY + 2; i++) nop("R7 drain");

    // R7: countdown through deselect and clock-disabled edges
    step("R4 open b2", 1'b1, 1'b0, 3'b011, 2'd2, 12'hABC);
    step("R7 read ap", 1'b1, 1'b0, 3'b101, 2'd2, 12'h455);
    step("R2 count continues", 1'b1, 1'b1, 3'b011, 2'd2, 12'h000);
    step("R3 count frozen", 1'b0, 1'b0, 3'b010, 2'd2, 12'h400);
    step("R3 count frozen", 1'b0, 1'b0, 3'b111, 2'd2, 12'h000);
    for (int i = 0; i < AP_DELAY; i++) nop("R7 ap close");
    // R7 restart
    step("R4 open b1", 1'b1, 1'b0, 3'b011, 2'd1, 12'h5A5);
    step("R7 write ap", 1'b1, 1'b0, 3'b100, 2'd1, 12'h401);
    nop("R7 wait"); nop("R7 wait");
    step("R7 write ap again", 1'b1, 1'b0, 3'b100, 2'd1, 12'h402);
    for (int i = 0; i < AP_DELAY + 1; i++) nop("R7 restart close");
    // R7 cancel by explicit precharge
    step("R4 open b3", 1'b1, 1'b0, 3'b011, 2'd3, 12'h0F0);
    step("R7 read ap", 1'b1, 1'b0, 3'b101, 2'd3, 12'h410);
    step("R7 precharge cancels", 1'b1, 1'b0, 3'b010, 2'd3, 12'h000);
    step("R4 reopen b3", 1'b1, 1'b0, 3'b011, 2'd3, 12'h0F1);
    for (int i = 0; i < AP_DELAY + 1; i++) nop("R7 cancel held");

    // R6: single and all-bank precharge
    for (int b = 0; b < 3; b++)
      step("R4 open", 1'b1, 1'b0, 3'b011, 2'(b), 12'h111 * 12'(b + 1));
    step("R6 single", 1'b1, 1'b0, 3'b010, 2'd1, 12'h000);
    step("R6 closed bank legal", 1'b1, 1'b0, 3'b010, 2'd1, 12'h000);
    step("R6 all", 1'b1, 1'b0, 3'b010, 2'd1, 12'h400);

    // R8: protocol violations
    step("R8 read closed", 1'b1, 1'b0, 3'b101, 2'd0, 12'h010);
    step("R8 write closed", 1'b1, 1'b0, 3'b100, 2'd2, 12'h410);
    step("R4 open b0", 1'b1, 1'b0, 3'b011, 2'd0, 12'h777);
    step("R8 act open", 1'b1, 1'b0, 3'b011, 2'd0, 12'h888);
    nop("R8 after");

    // R9: mask combinations, same cycle
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      wvld = v[1]; dm = v[0];
      #1;
      check_vec("R9 mask", {91'b0, byte_we_o}, {91'b0, v[1] & ~v[0]});
    end
    wvld = 1'b0; dm = 1'b0;

    // R10: reset with a bank open
    do_reset();
    nop("R10 idle");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule